// File: doc/BRIEF.md
# Latched BCD Seven-Segment Digit with Zero Suppression

This block stores one BCD digit in a register and shows the stored value on a seven-segment digit with a decimal point. A hold input freezes the stored value, so the producer of the digit, usually a decade counter, keeps running while the display stays steady. The stored value also leaves the block as a parallel 4-bit word, so other logic can read what is being shown.

Digits can be chained to suppress leading or trailing zeros. Each digit takes a zero-suppress request from its neighbour. It blanks itself when that request is active and its own stored value is zero, and it passes the request on through its active-low ripple output. A force-blank input turns off the whole digit, including the decimal point, and pulls the ripple output low. An external active-low blank request stands in for a wired-AND on the ripple node. It is ANDed with the internal ripple output, and the display blanks whenever the combined node is low.

Top module: `bcd_seg_display`

## Requirements
- R1: While `hold` is low, `q` takes the value of `bcd_in` at every rising clock edge.
- R2: While `hold` is high, `q` keeps its value across clock edges, whatever `bcd_in` does.
- R3: `q` carries bit weights 1, 2, 4 and 8 on `q[0]` to `q[3]`. An active reset sets `q` to 0.
- R4: `seg[0]` to `seg[6]` drive segments a to g and are active high. The codes for 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. Stored values 10 to 15 turn all segments off.
- R5: When `blank_force` is high, `seg` is 0, `dp_out` is 0 and `rb_out_n` is low.
- R6: When `rb_in_n` is low and `q` is 0, the digit is fully blanked and `rb_out_n` is low. When `q` is not 0, `rb_in_n` has no effect.
- R7: `rb_out_n` is high whenever neither the R5 condition nor the R6 condition holds.
- R8: When `ext_blank_n` is low, `seg` and `dp_out` are 0. `rb_out_n` is not affected by it.
- R9: `dp_out` follows `dp_in` whenever the digit is not blanked, including for stored values 10 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_in | input | 4 | BCD digit from the counter |
| hold | input | 1 | High freezes the stored digit |
| blank_force | input | 1 | High blanks the whole digit |
| rb_in_n | input | 1 | Active-low zero-suppress request from the neighbour |
| dp_in | input | 1 | Decimal point request |
| ext_blank_n | input | 1 | External active-low pull on the ripple node |
| rb_out_n | output | 1 | Active-low ripple output to the next digit |
| q | output | 4 | Stored digit |
| seg | output | 7 | Segment enables a..g |
| dp_out | output | 1 | Decimal point enable |

## Verification
The assertions check the following relations on every cycle:
- the hold and load behaviour of the stored digit;
- force blanking and its effect on the ripple output;
- zero suppression;
- the external pull;
- gating of the decimal point;
- the all-off rule for invalid codes.

The exact segment pattern of each digit, the reset value, and multi-cycle hold-then-release sequences can only be shown by the bench's scenarios.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_N   = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_N-1:0]   seg_t;

  // Segment order: bit0 = a ... bit6 = g, active high.
  function automatic seg_t digit_to_seg(input digit_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/digit_latch.sv
module digit_latch
  import bcd_seg_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_q
);
  logic         load_en;
  logic [W-1:0] d_next;

  assign load_en = ~hold;

  always_comb begin
    d_next = d_q;
    if (load_en) d_next = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= '0;
    else        d_q <= d_next;
  end
endmodule

// File: rtl/blank_ctrl.sv
module blank_ctrl
  import bcd_seg_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  logic [W-1:0] d_q,
  input  logic         blank_force,
  input  logic         rb_in_n,
  input  logic         ext_blank_n,
  output logic         rb_out_n,
  output logic         blank
);
  logic is_zero;
  logic node_n;

  assign is_zero  = (d_q == '0);
  assign rb_out_n = ~(blank_force | (~rb_in_n & is_zero));
  assign node_n   = rb_out_n & ext_blank_n;  // wired-AND of the ripple node
  assign blank    = ~node_n;
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import bcd_seg_pkg::*;
#(
  parameter int W = DIGIT_W,
  parameter int S = SEG_N
) (
  input  logic [W-1:0] d_q,
  input  logic         blank,
  input  logic         dp_in,
  output logic [S-1:0] seg,
  output logic         dp_out
);
  seg_t raw;

  always_comb begin
    raw = digit_to_seg(digit_t'(d_q));
  end

  genvar i;
  generate
    for (i = 0; i < S; i++) begin : g_seg
      assign seg[i] = raw[i] & ~blank;
    end
  endgenerate

  assign dp_out = dp_in & ~blank;
endmodule

// File: rtl/bcd_seg_display.sv
module bcd_seg_display
  import bcd_seg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] bcd_in,
  input  logic               hold,
  input  logic               blank_force,
  input  logic               rb_in_n,
  input  logic               dp_in,
  input  logic               ext_blank_n,
  output logic               rb_out_n,
  output logic [DIGIT_W-1:0] q,
  output logic [SEG_N-1:0]   seg,
  output logic               dp_out
);
  logic blank;

  digit_latch #(.W(DIGIT_W)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (hold),
    .d_in (bcd_in),
    .d_q  (q)
  );

  blank_ctrl #(.W(DIGIT_W)) u_blank (
    .d_q        (q),
    .blank_force(blank_force),
    .rb_in_n    (rb_in_n),
    .ext_blank_n(ext_blank_n),
    .rb_out_n   (rb_out_n),
    .blank      (blank)
  );

  seg_decoder #(.W(DIGIT_W), .S(SEG_N)) u_dec (
    .d_q   (q),
    .blank (blank),
    .dp_in (dp_in),
    .seg   (seg),
    .dp_out(dp_out)
  );
endmodule

// File: rtl/bcd_seg_display_chk.sv
module bcd_seg_display_chk
  import bcd_seg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [DIGIT_W-1:0] bcd_in,
  input logic               hold,
  input logic               blank_force,
  input logic               rb_in_n,
  input logic               dp_in,
  input logic               ext_blank_n,
  input logic               rb_out_n,
  input logic [DIGIT_W-1:0] q,
  input logic [SEG_N-1:0]   seg,
  input logic               dp_out
);
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (q == $past(bcd_in)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(q));

  a_r4_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
    (q > MAX_DIGIT) |-> (seg == '0));

  a_r5_force_blank: assert property (@(posedge clk) disable iff (!rst_n)
    blank_force |-> (seg == '0 && !dp_out && !rb_out_n));

  a_r6_zero_suppress: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb_in_n && q == '0) |-> (seg == '0 && !dp_out && !rb_out_n));

  a_r7_rbo_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_force && (rb_in_n || q != '0)) |-> rb_out_n);

  a_r8_ext_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_blank_n |-> (seg == '0 && !dp_out));

  a_r9_dp_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_out_n && ext_blank_n) |-> (dp_out == dp_in));
endmodule

bind bcd_seg_display bcd_seg_display_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .hold(hold),
  .blank_force(blank_force), .rb_in_n(rb_in_n), .dp_in(dp_in),
  .ext_blank_n(ext_blank_n), .rb_out_n(rb_out_n), .q(q), .seg(seg),
  .dp_out(dp_out)
);

// File: tb/test_bcd_seg_display.sv
module test_bcd_seg_display;
  logic       clk;
  logic       rst_n;
  logic [3:0] bcd_in;
  logic       hold, blank_force, rb_in_n, dp_in, ext_blank_n;
  logic       rb_out_n, dp_out;
  logic [3:0] q;
  logic [6:0] seg;

  int checks = 0;
  int errors = 0;

  bcd_seg_display i_bcd_seg_display (
    .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .hold(hold),
    .blank_force(blank_force), .rb_in_n(rb_in_n), .dp_in(dp_in),
    .ext_blank_n(ext_blank_n), .rb_out_n(rb_out_n), .q(q), .seg(seg),
    .dp_out(dp_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // {bcd, force, rb_in_n, dp, ext_n, exp_seg, exp_dp, exp_rbo}
  typedef struct packed {
    logic [3:0] bcd;
    logic       bf;
    logic       rbi_n;
    logic       dp;
    logic       ext_n;
    logic [6:0] e_seg;
    logic       e_dp;
    logic       e_rbo;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 7'h3F, 1'b0, 1'b1},  // R4
    '{4'd1, 1'b0, 1'b1, 1'b1, 1'b1, 7'h06, 1'b1, 1'b1},  // R4 R9
    '{4'd2, 1'b0, 1'b1, 1'b0, 1'b1, 7'h5B, 1'b0, 1'b1},
    '{4'd3, 1'b0, 1'b1, 1'b1, 1'b1, 7'h4F, 1'b1, 1'b1},
    '{4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 7'h66, 1'b0, 1'b1},
    '{4'd5, 1'b0, 1'b1, 1'b1, 1'b1, 7'h6D, 1'b1, 1'b1},
    '{4'd6, 1'b0, 1'b1, 1'b0, 1'b1, 7'h7D, 1'b0, 1'b1},
    '{4'd7, 1'b0, 1'b1, 1'b1, 1'b1, 7'h07, 1'b1, 1'b1},
    '{4'd8, 1'b0, 1'b1, 1'b0, 1'b1, 7'h7F, 1'b0, 1'b1},
    '{4'd9, 1'b0, 1'b1, 1'b1, 1'b1, 7'h6F, 1'b1, 1'b1},
    '{4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 7'h00, 1'b0, 1'b0},  // R6 zero suppressed
    '{4'd5, 1'b0, 1'b0, 1'b1, 1'b1, 7'h6D, 1'b1, 1'b1},  // R6 no effect, R7
    '{4'd3, 1'b1, 1'b1, 1'b1, 1'b1, 7'h00, 1'b0, 1'b0},  // R5
    '{4'd0, 1'b1, 1'b0, 1'b1, 1'b1, 7'h00, 1'b0, 1'b0},  // R5 with R6
    '{4'd7, 1'b0, 1'b1, 1'b1, 1'b0, 7'h00, 1'b0, 1'b1},  // R8
    '{4'd12,1'b0, 1'b1, 1'b1, 1'b1, 7'h00, 1'b1, 1'b1},  // R4 invalid, R9
    '{4'd15,1'b0, 1'b1, 1'b0, 1'b1, 7'h00, 1'b0, 1'b1},  // R4 invalid
    '{4'd10,1'b0, 1'b0, 1'b1, 1'b1, 7'h00, 1'b1, 1'b1}   // R6 nonzero, R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bcd_in = 4'd6; hold = 1'b0; blank_force = 1'b0;
    rb_in_n = 1'b1; dp_in = 1'b0; ext_blank_n = 1'b1;
    #20;
    check("R3 reset q", {4'd0, q}, 8'd0);
    check("R4 reset seg", {1'b0, seg}, 8'h3F);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector walk: drive at falling edge, load at rising edge, sample at next falling edge.
    for (int i = 0; i < NV; i++) begin
      bcd_in = VECS[i].bcd; blank_force = VECS[i].bf; rb_in_n = VECS[i].rbi_n;
      dp_in = VECS[i].dp; ext_blank_n = VECS[i].ext_n;
      @(posedge clk);
      @(negedge clk);
      check("R1 R3 q", {4'd0, q}, {4'd0, VECS[i].bcd});
      check("R4 R5 R6 R8 seg", {1'b0, seg}, {1'b0, VECS[i].e_seg});
      check("R9 dp_out", {7'd0, dp_out}, {7'd0, VECS[i].e_dp});
      check("R5 R6 R7 rb_out_n", {7'd0, rb_out_n}, {7'd0, VECS[i].e_rbo});
    end

    // Hold: store 4, freeze, change input for several cycles.
    blank_force = 1'b0; rb_in_n = 1'b1; ext_blank_n = 1'b1; dp_in = 1'b0;
    bcd_in = 4'd4;
    @(posedge clk); @(negedge clk);
    hold = 1'b1; bcd_in = 4'd8;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      check("R2 held q", {4'd0, q}, 8'd4);
      check("R2 held seg", {1'b0, seg}, 8'h66);
    end
    hold = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 release q", {4'd0, q}, 8'd8);

    // Zero held while neighbour requests suppression.
    bcd_in = 4'd0;
    @(posedge clk); @(negedge clk);
    hold = 1'b1; bcd_in = 4'd9; rb_in_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6 held zero rb_out_n", {7'd0, rb_out_n}, 8'd0);
    check("R2 R6 held zero seg", {1'b0, seg}, 8'h00);

    // External pull does not change ripple output; releasing restores display.
    rb_in_n = 1'b1; ext_blank_n = 1'b0; dp_in = 1'b1;
    #1;
    check("R8 rb_out_n unaffected", {7'd0, rb_out_n}, 8'd1);
    check("R8 dp off", {7'd0, dp_out}, 8'd0);
    ext_blank_n = 1'b1;
    #1;
    check("R9 dp restored", {7'd0, dp_out}, 8'd1);
    check("R4 zero shown", {1'b0, seg}, 8'h3F);

    // Asynchronous reset clears a held value.
    rst_n = 1'b0;
    #1;
    check("R3 async reset", {4'd0, q}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    hold = 1'b0;

    finish_run();
  end
endmodule